// File: doc/BRIEF.md
# Three-Wire Control Bus Receiver

This block is a write-only slave for a three-wire control bus made of a mode line, a bus clock and a data line. A fast system clock oversamples all three lines. The block puts bus bits together into bytes and tells address bytes apart from data bytes by the level of the mode line. It checks a fixed 6-bit device address, keeps track of which register set is selected, and decodes each data byte into one of several independent configuration registers.

The register values leave the block as parallel outputs. They cover the conversion-clock ratio, the serial sample format, the DC-filter enable, the volume attenuation, the de-emphasis choice, mute, and separate power enables for the ADC and the DAC. Each register update also produces a one-cycle write strobe together with a code that names the register, so that downstream logic can react to the change.

The bus master sends an address byte with the mode line low and then any number of data bytes with the mode line high. Each data byte is sent least significant bit first and is acted on only once all eight bits have arrived.

Top module: `ctl3w_rx`

## Requirements
- R1: While reset is active and after it is released, the outputs hold these defaults: volume code 0, mute off, de-emphasis 00, rate code 10, format 000, DC filter off, ADC enable 1, DAC enable 1, write strobe 0. No register set is selected.
- R2: An address byte sent with the mode line low, with bits 7:2 equal to 000101 and bits 1:0 equal to 10, selects the status set. After that, a data byte whose bits 7:6 are 00 loads the rate code from bits 5:4, the format code from bits 3:1 and the DC-filter enable from bit 0. A status-set data byte with bits 7:6 not equal to 00 changes nothing.
- R3: An address byte whose bits 1:0 are 00 selects the data set. Its data bytes are decoded by bits 7:6. Code 00 loads the volume from bits 5:0. Code 10 loads de-emphasis from bits 4:3 and mute from bit 2. Code 11 loads the ADC enable from bit 1 and the DAC enable from bit 0. Code 01 changes nothing.
- R4: Bits are taken on rising edges of the bus clock, least significant bit first. A byte is acted on only after its eighth bit. A change of the mode line throws away a partly received byte.
- R5: An address byte whose bits 7:2 are not 000101 deselects the block. Data bytes that follow it change no output.
- R6: Set codes 01 and 11 in an address byte select no set. Data bytes that follow them change no output.
- R7: A selected set stays in force for any number of data bytes, until the next address byte arrives.
- R8: Every register load raises the write strobe for exactly one system clock, with an identifier: 0 for status, 1 for volume, 2 for de-emphasis/mute, 3 for power. The outputs change on the fourth system clock edge after the first edge that samples the eighth rising bus clock edge high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbus_mode_i | input | 1 | Bus mode line: low for address, high for data |
| cbus_clk_i | input | 1 | Bus clock line |
| cbus_dat_i | input | 1 | Bus data line |
| rate_sel_o | output | 2 | Conversion clock ratio code |
| fmt_sel_o | output | 3 | Serial sample format code |
| dcf_en_o | output | 1 | DC cancellation filter enable |
| vol_att_o | output | 6 | Volume attenuation code |
| deemph_o | output | 2 | De-emphasis select |
| mute_o | output | 1 | Playback mute |
| adc_en_o | output | 1 | ADC power enable |
| dac_en_o | output | 1 | DAC power enable |
| wr_stb_o | output | 1 | One-cycle register-load strobe |
| wr_id_o | output | 2 | Identifier of the register just loaded |

## Verification
A wrong bit count or a wrong bit order inside the deserialiser shows up on the first complete data byte. That byte lands in the wrong register field, or it lands with shifted values, four system cycles after its eighth bus clock edge. A wrong register-set selection is harder to catch: it stays hidden until the next data byte, which then either writes where it should not or fails to write. For that reason the reference model is compared against every output on every clock, and the bench follows each kind of address byte with at least one data byte.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DADDR_W = 6;

  localparam logic [1:0] SET_DATA   = 2'b00;
  localparam logic [1:0] SET_STATUS = 2'b10;

  localparam logic [1:0] RID_STATUS = 2'd0;
  localparam logic [1:0] RID_VOLUME = 2'd1;
  localparam logic [1:0] RID_TONE   = 2'd2;
  localparam logic [1:0] RID_POWER  = 2'd3;

  typedef struct packed {
    logic [1:0] rate_sel;
    logic [2:0] fmt_sel;
    logic       dcf_en;
    logic [5:0] vol_att;
    logic [1:0] deemph;
    logic       mute;
    logic       adc_en;
    logic       dac_en;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{
    rate_sel: 2'b10,
    fmt_sel:  3'b000,
    dcf_en:   1'b0,
    vol_att:  6'd0,
    deemph:   2'b00,
    mute:     1'b0,
    adc_en:   1'b1,
    dac_en:   1'b1
  };

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= '0;
    else        pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= '0;
      else        pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/ctl3w_deser.sv
module ctl3w_deser #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_s_i,
  input  logic            sclk_s_i,
  input  logic            sdat_s_i,
  output logic            byte_stb_o,
  output logic [BITS-1:0] byte_o,
  output logic            byte_mode_o
);

  localparam int unsigned CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic            sclk_d_q, mode_d_q;
  logic [CW-1:0]   cnt_q, cnt_n, cnt_base;
  logic [BITS-1:0] shr_q, shr_n;
  logic            stb_q, stb_n;
  logic [BITS-1:0] byte_q, byte_n;
  logic            bmode_q, bmode_n;
  logic            rise, mode_chg;

  assign rise     = sclk_s_i & ~sclk_d_q;
  assign mode_chg = mode_s_i ^ mode_d_q;

  always_comb begin
    cnt_base = mode_chg ? '0 : cnt_q;
    cnt_n    = cnt_base;
    shr_n    = shr_q;
    stb_n    = 1'b0;
    byte_n   = byte_q;
    bmode_n  = bmode_q;
    if (rise) begin
      shr_n = {sdat_s_i, shr_q[BITS-1:1]};
      if (cnt_base == LAST) begin
        cnt_n   = '0;
        stb_n   = 1'b1;
        byte_n  = shr_n;
        bmode_n = mode_s_i;
      end else begin
        cnt_n = cnt_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      mode_d_q <= 1'b0;
      cnt_q    <= '0;
      shr_q    <= '0;
      stb_q    <= 1'b0;
      byte_q   <= '0;
      bmode_q  <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s_i;
      mode_d_q <= mode_s_i;
      cnt_q    <= cnt_n;
      shr_q    <= shr_n;
      stb_q    <= stb_n;
      byte_q   <= byte_n;
      bmode_q  <= bmode_n;
    end
  end

  assign byte_stb_o  = stb_q;
  assign byte_o      = byte_q;
  assign byte_mode_o = bmode_q;

  // R4: a completed byte always follows a detected bus clock rise
  assert_byte_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(rise));

  // R4: two byte completions can never be adjacent
  assert_no_double_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
  import ctl3w_pkg::*;
#(
  parameter logic [DADDR_W-1:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_mode_i,
  output cfg_t              cfg_o,
  output logic              wr_o,
  output logic [1:0]        wr_id_o
);

  cfg_t       cfg_q, cfg_n;
  logic       sel_data_q, sel_data_n;
  logic       sel_stat_q, sel_stat_n;
  logic       wr_q, wr_n;
  logic [1:0] id_q, id_n;

  always_comb begin
    cfg_n      = cfg_q;
    sel_data_n = sel_data_q;
    sel_stat_n = sel_stat_q;
    wr_n       = 1'b0;
    id_n       = id_q;
    if (byte_stb_i) begin
      if (!byte_mode_i) begin
        if (byte_i[BYTE_W-1:2] == DEV_ADDR) begin
          sel_data_n = (byte_i[1:0] == SET_DATA);
          sel_stat_n = (byte_i[1:0] == SET_STATUS);
        end else begin
          sel_data_n = 1'b0;
          sel_stat_n = 1'b0;
        end
      end else if (sel_stat_q) begin
        if (byte_i[7:6] == 2'b00) begin
          cfg_n.rate_sel = byte_i[5:4];
          cfg_n.fmt_sel  = byte_i[3:1];
          cfg_n.dcf_en   = byte_i[0];
          wr_n           = 1'b1;
          id_n           = RID_STATUS;
        end
      end else if (sel_data_q) begin
        case (byte_i[7:6])
          2'b00: begin
            cfg_n.vol_att = byte_i[5:0];
            wr_n          = 1'b1;
            id_n          = RID_VOLUME;
          end
          2'b10: begin
            cfg_n.deemph = byte_i[4:3];
            cfg_n.mute   = byte_i[2];
            wr_n         = 1'b1;
            id_n         = RID_TONE;
          end
          2'b11: begin
            cfg_n.adc_en = byte_i[1];
            cfg_n.dac_en = byte_i[0];
            wr_n         = 1'b1;
            id_n         = RID_POWER;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_DEFAULT;
      sel_data_q <= 1'b0;
      sel_stat_q <= 1'b0;
      wr_q       <= 1'b0;
      id_q       <= RID_STATUS;
    end else begin
      cfg_q      <= cfg_n;
      sel_data_q <= sel_data_n;
      sel_stat_q <= sel_stat_n;
      wr_q       <= wr_n;
      id_q       <= id_n;
    end
  end

  assign cfg_o   = cfg_q;
  assign wr_o    = wr_q;
  assign wr_id_o = id_q;

  // R8: a write strobe only follows a completed data-mode byte
  assert_wr_after_data_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> ($past(byte_stb_i) && $past(byte_mode_i)));

  // R5: with nothing selected a data byte writes nothing
  assert_deselected_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb_i && byte_mode_i && !sel_data_q && !sel_stat_q) |=> !wr_q);

  // R2: the rate code only moves together with a status write strobe
  assert_rate_moves_on_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q.rate_sel) |-> (wr_q && id_q == RID_STATUS));

  // R3: the volume code only moves together with a volume write strobe
  assert_vol_moves_on_volume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q.vol_att) |-> (wr_q && id_q == RID_VOLUME));

  // R7: data bytes leave the selection unchanged
  assert_sel_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb_i && byte_mode_i) |=> $stable({sel_data_q, sel_stat_q}));

  // R6: at most one register set is ever selected
  assert_single_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_data_q, sel_stat_q}));

endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cbus_mode_i,
  input  logic       cbus_clk_i,
  input  logic       cbus_dat_i,
  output logic [1:0] rate_sel_o,
  output logic [2:0] fmt_sel_o,
  output logic       dcf_en_o,
  output logic [5:0] vol_att_o,
  output logic [1:0] deemph_o,
  output logic       mute_o,
  output logic       adc_en_o,
  output logic       dac_en_o,
  output logic       wr_stb_o,
  output logic [1:0] wr_id_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [2:0]        lines_s;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;
  logic              byte_mode;
  cfg_t              cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({cbus_mode_i, cbus_clk_i, cbus_dat_i}),
    .q_o   (lines_s)
  );

  ctl3w_deser #(.BITS(BYTE_W)) u_deser (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode_s_i    (lines_s[2]),
    .sclk_s_i    (lines_s[1]),
    .sdat_s_i    (lines_s[0]),
    .byte_stb_o  (byte_stb),
    .byte_o      (byte_val),
    .byte_mode_o (byte_mode)
  );

  ctl3w_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .byte_stb_i  (byte_stb),
    .byte_i      (byte_val),
    .byte_mode_i (byte_mode),
    .cfg_o       (cfg),
    .wr_o        (wr_stb_o),
    .wr_id_o     (wr_id_o)
  );

  assign rate_sel_o = cfg.rate_sel;
  assign fmt_sel_o  = cfg.fmt_sel;
  assign dcf_en_o   = cfg.dcf_en;
  assign vol_att_o  = cfg.vol_att;
  assign deemph_o   = cfg.deemph;
  assign mute_o     = cfg.mute;
  assign adc_en_o   = cfg.adc_en;
  assign dac_en_o   = cfg.dac_en;

endmodule

// File: tb/ctl3w_rx_test.sv
module ctl3w_rx_test;

  localparam int HALF = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bmode, bclk, bdat;
  logic [1:0] rate_sel, deemph, wr_id;
  logic [2:0] fmt_sel;
  logic [5:0] vol_att;
  logic dcf_en, mute, adc_en, dac_en, wr_stb;

  ctl3w_rx uut (
    .clk(clk), .rst_n(rst_n), .cbus_mode_i(bmode), .cbus_clk_i(bclk), .cbus_dat_i(bdat),
    .rate_sel_o(rate_sel), .fmt_sel_o(fmt_sel), .dcf_en_o(dcf_en), .vol_att_o(vol_att),
    .deemph_o(deemph), .mute_o(mute), .adc_en_o(adc_en), .dac_en_o(dac_en),
    .wr_stb_o(wr_stb), .wr_id_o(wr_id)
  );

  int checks = 0, errors = 0, cyc = 0, apply_at = -1;
  bit chk_en = 0;
  string cur_req = "R1";
  int msel = -1;
  int e_rate = 2, e_fmt = 0, e_dcf = 0, e_vol = 0, e_dem = 0, e_mute = 0, e_adc = 1, e_dac = 1;
  int p_rate, p_fmt, p_dcf, p_vol, p_dem, p_mute, p_adc, p_dac, p_id;
  int cur_id = 0;
  bit ew;

  always @(posedge clk) cyc = cyc + 1;

  task automatic cmp(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      ew = 1'b0;
      if (cyc == apply_at) begin
        e_rate = p_rate; e_fmt = p_fmt; e_dcf = p_dcf; e_vol = p_vol;
        e_dem = p_dem; e_mute = p_mute; e_adc = p_adc; e_dac = p_dac;
        cur_id = p_id; ew = 1'b1;
      end
      cmp(cur_req, "rate", rate_sel, e_rate);
      cmp(cur_req, "fmt", fmt_sel, e_fmt);
      cmp(cur_req, "dcf", dcf_en, e_dcf);
      cmp(cur_req, "vol", vol_att, e_vol);
      cmp(cur_req, "deemph", deemph, e_dem);
      cmp(cur_req, "mute", mute, e_mute);
      cmp(cur_req, "adc", adc_en, e_adc);
      cmp(cur_req, "dac", dac_en, e_dac);
      cmp("R8", "wr_stb", wr_stb, ew);
      if (ew) cmp("R8", "wr_id", wr_id, cur_id);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Reference decode of one byte; returns 1 when a register load is due
  function automatic bit model(bit is_data, logic [7:0] b);
    p_rate = e_rate; p_fmt = e_fmt; p_dcf = e_dcf; p_vol = e_vol;
    p_dem = e_dem; p_mute = e_mute; p_adc = e_adc; p_dac = e_dac;
    if (!is_data) begin
      if (b[7:2] == 6'd5 && (b[1:0] == 2'd0 || b[1:0] == 2'd2)) msel = b[1:0];
      else msel = -1;
      return 1'b0;
    end
    if (msel == 2) begin
      if (b[7:6] != 0) return 1'b0;
      p_rate = b[5:4]; p_fmt = b[3:1]; p_dcf = b[0]; p_id = 0;
      return 1'b1;
    end
    if (msel == 0) begin
      if (b[7:6] == 2'd0) begin p_vol = b[5:0]; p_id = 1; return 1'b1; end
      if (b[7:6] == 2'd2) begin p_dem = b[4:3]; p_mute = b[2]; p_id = 2; return 1'b1; end
      if (b[7:6] == 2'd3) begin p_adc = b[1]; p_dac = b[0]; p_id = 3; return 1'b1; end
    end
    return 1'b0;
  endfunction

  task automatic send_bits(logic [7:0] b, int n, bit will_wr);
    for (int i = 0; i < n; i++) begin
      bdat = b[i];
      tick(HALF);
      bclk = 1'b1;
      if (i == 7 && will_wr) apply_at = cyc + 4;
      tick(HALF);
      bclk = 1'b0;
    end
  endtask

  task automatic send_byte(bit is_data, logic [7:0] b);
    bit w;
    bmode = is_data;
    tick(HALF);
    w = model(is_data, b);
    send_bits(b, 8, w);
    tick(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-requirements act=running exp=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bmode = 1'b1; bclk = 1'b0; bdat = 1'b0;
    tick(3);
    cur_req = "R1"; chk_en = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(10);

    cur_req = "R2";                  // status set, then a load and an ignored byte
    send_byte(0, 8'h16);
    send_byte(1, 8'h1B);
    send_byte(1, 8'h7F);

    cur_req = "R7";                  // second status byte without readdressing
    send_byte(1, 8'h20);

    cur_req = "R3";                  // data set sub-registers
    send_byte(0, 8'h14);
    send_byte(1, 8'h2A);
    send_byte(1, 8'h7F);
    send_byte(1, 8'h94);
    send_byte(1, 8'hC2);
    send_byte(1, 8'hC1);

    cur_req = "R5";                  // foreign address deselects
    send_byte(0, 8'h1C);
    send_byte(1, 8'h05);
    send_byte(1, 8'hC0);

    cur_req = "R6";                  // unused set codes select nothing
    send_byte(0, 8'h15);
    send_byte(1, 8'h11);
    send_byte(0, 8'h17);
    send_byte(1, 8'h00);

    cur_req = "R4";                  // partial byte is dropped by a mode change
    send_byte(0, 8'h14);
    bmode = 1'b1;
    tick(HALF);
    send_bits(8'hFF, 5, 1'b0);
    bmode = 1'b0; tick(HALF);
    bmode = 1'b1; tick(HALF);
    send_byte(1, 8'h0B);
    send_byte(1, 8'h30);

    tick(20);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule